// File: doc/BRIEF.md
# Stress Disturbance Force Controller

This block drives a set of force lines used to stress a processor design. Each line is meant to be ORed into one native condition of the design, such as a queue-full or stall flag. A line can only add that condition and never hide it. For every channel the controller waits until the channel is enabled and its trigger input is high. It then raises the force line for a pseudo-random number of cycles, drops it for a pseudo-random number of cycles, and starts over while the trigger holds.

The timing comes from one shared 16-bit Galois LFSR that steps every cycle. Each channel reads its own rotated slice of the LFSR and clamps the value into a per-channel [min, max] window, once for the high phase and once for the low phase. A per-channel limit caps how many injections a channel completes. An exclusion matrix keeps conflicting channels from being forced together. A sticky per-channel flag and a per-channel occurrence count show whether a condition was ever forced. A synchronous clear resets all channels and reloads the LFSR from the seed input.

Top module: `dist_inject_ctrl`

## Requirements
- R1: After reset, every force line, sticky flag and occurrence count is 0. A one-cycle `clear_i` returns every channel to that state. It also reloads the LFSR from `seed_i`, so identical stimulus after two clears produces identical pulse widths.
- R2: A channel raises its force line only if it was enabled and its trigger was high in the cycle before. When a channel is waiting and its trigger rises, force goes high at the next clock edge.
- R3: A high phase lasts between max(min,1) and max cycles. A max below that lower bound yields the lower bound, and a min equal to the max gives exactly that many cycles. A low phase obeys the same rule with its own window. With the trigger held, the next high phase starts one cycle after the low phase ends, so the gap between pulses is the low phase plus 1.
- R4: When a channel's enable drops during a high phase, force goes low at the next edge, and the aborted pulse is not counted.
- R5: The occurrence count rises by 1 at the end of each complete high phase. Once the count equals the limit, the channel never forces again until clear or reset. A limit of 0 means the channel never forces.
- R6: When bit [i*4+j] or bit [j*4+i] of `excl_i` is set, channels i and j are never forced in the same cycle. A channel does not start while an excluded partner is high. It starts later, once the partner has dropped.
- R7: When channels that exclude each other would start in the same cycle, the lowest index starts and the others keep waiting.
- R8: A channel's sticky flag is set the cycle after its force line was high. It stays set until clear or reset.
- R9: Channels with no exclusion between them run independently and may be forced in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous global clear and seed reload |
| seed_i | input | 16 | LFSR seed (0 is replaced by 1) |
| enable_i | input | 4 | Per-channel enable |
| trig_i | input | 4 | Per-channel trigger window |
| on_min_i | input | 32 | Per-channel minimum high length, 8 bits per channel |
| on_max_i | input | 32 | Per-channel maximum high length |
| off_min_i | input | 32 | Per-channel minimum low length |
| off_max_i | input | 32 | Per-channel maximum low length |
| occ_limit_i | input | 32 | Per-channel injection cap, 8 bits per channel |
| excl_i | input | 16 | Exclusion matrix, bit i*4+j pairs channel i with j |
| force_o | output | 4 | Force lines to OR into the target conditions |
| forced_seen_o | output | 4 | Sticky "was forced" flags |
| occ_count_o | output | 32 | Completed injections per channel, 8 bits each |

## Verification
The bench targets the boundaries where a wrong controller would still look plausible. It holds the trigger low for a long stretch to confirm nothing fires, which catches a design that starts without its window. It uses a limit of 0 and an exact limit of 2 to catch off-by-one caps that allow an extra pulse. It drops the enable in the middle of a pulse to catch a pulse that runs on or is counted. Two excluded channels trigger in the same cycle, and any overlap or the wrong winner is reported. A zero-width window checks the 1-cycle floor, and two runs with matching timing after separate clears must give the same pulse widths. Two unrelated channels that are held apart would show up as a missing simultaneous pulse.

// File: rtl/dist_inj_pkg.sv
package dist_inj_pkg;

    typedef enum logic [2:0] {
        CH_IDLE = 3'd0,
        CH_WAIT = 3'd1,
        CH_ON   = 3'd2,
        CH_OFF  = 3'd3,
        CH_DONE = 3'd4
    } ch_state_e;

endpackage

// File: rtl/dist_lfsr.sv
module dist_lfsr #(
    parameter int          LW         = 16,
    parameter logic [15:0] TAPS       = 16'hB400,
    parameter logic [15:0] RESET_SEED = 16'h0001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic [LW-1:0] seed_i,
    output logic [LW-1:0] state_o
);

    logic [LW-1:0] lfsr_d, lfsr_q;
    logic [LW-1:0] seed_safe;

    assign seed_safe = (seed_i == '0) ? LW'(1) : seed_i;

    always_comb begin
        lfsr_d = {1'b0, lfsr_q[LW-1:1]};
        if (lfsr_q[0]) begin
            lfsr_d = lfsr_d ^ TAPS[LW-1:0];
        end
        if (clear_i) begin
            lfsr_d = seed_safe;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= RESET_SEED[LW-1:0];
        end else begin
            lfsr_q <= lfsr_d;
        end
    end

    assign state_o = lfsr_q;

    // R3: a stuck-at-zero generator would freeze every duration
    a_r3_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

endmodule

// File: rtl/dist_excl_arb.sv
module dist_excl_arb #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0]     req_i,
    input  logic [NCH-1:0]     on_i,
    input  logic [NCH*NCH-1:0] excl_i,
    output logic [NCH-1:0]     grant_o
);

    always_comb begin
        logic [NCH-1:0] g;
        g = '0;
        for (int i = 0; i < NCH; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < NCH; j++) begin
                if (j != i && (excl_i[i*NCH+j] || excl_i[j*NCH+i])) begin
                    if (on_i[j]) blocked = 1'b1;
                    if (j < i && g[j]) blocked = 1'b1;
                end
            end
            g[i] = req_i[i] && !blocked;
        end
        grant_o = g;
    end

endmodule

// File: rtl/dist_channel.sv
module dist_channel
    import dist_inj_pkg::*;
#(
    parameter int DW = 8,
    parameter int OW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          en_i,
    input  logic          trig_i,
    input  logic          grant_i,
    input  logic [DW-1:0] draw_i,
    input  logic [DW-1:0] on_min_i,
    input  logic [DW-1:0] on_max_i,
    input  logic [DW-1:0] off_min_i,
    input  logic [DW-1:0] off_max_i,
    input  logic [OW-1:0] occ_limit_i,
    output logic          req_o,
    output logic          force_o,
    output logic          seen_o,
    output logic [OW-1:0] occ_o
);

    typedef struct packed {
        ch_state_e     st;
        logic [DW-1:0] tmr;
        logic [OW-1:0] occ;
        logic          seen;
    } ch_regs_t;

    ch_regs_t r_d, r_q;

    function automatic logic [DW-1:0] fit(input logic [DW-1:0] raw,
                                          input logic [DW-1:0] lo_in,
                                          input logic [DW-1:0] hi);
        logic [DW-1:0] lo;
        logic [DW-1:0] v;
        lo = (lo_in == '0) ? DW'(1) : lo_in;
        v  = raw;
        if (v > hi) v = hi;
        if (v < lo) v = lo;
        return v;
    endfunction

    logic below_cap;
    assign below_cap = r_q.occ < occ_limit_i;

    always_comb begin
        r_d      = r_q;
        r_d.seen = r_q.seen | (r_q.st == CH_ON);
        unique case (r_q.st)
            CH_IDLE: begin
                if (en_i) r_d.st = CH_WAIT;
            end
            CH_WAIT: begin
                if (!en_i) begin
                    r_d.st = CH_IDLE;
                end else if (!below_cap) begin
                    r_d.st = CH_DONE;
                end else if (grant_i) begin
                    r_d.st  = CH_ON;
                    r_d.tmr = fit(draw_i, on_min_i, on_max_i) - DW'(1);
                end
            end
            CH_ON: begin
                if (!en_i) begin
                    r_d.st = CH_IDLE;
                end else if (r_q.tmr == '0) begin
                    r_d.st  = CH_OFF;
                    r_d.tmr = fit(draw_i, off_min_i, off_max_i) - DW'(1);
                    r_d.occ = r_q.occ + OW'(1);
                end else begin
                    r_d.tmr = r_q.tmr - DW'(1);
                end
            end
            CH_OFF: begin
                if (!en_i) begin
                    r_d.st = CH_IDLE;
                end else if (r_q.tmr == '0) begin
                    r_d.st = CH_WAIT;
                end else begin
                    r_d.tmr = r_q.tmr - DW'(1);
                end
            end
            CH_DONE: begin
                r_d.st = CH_DONE;
            end
            default: r_d.st = CH_IDLE;
        endcase
        if (clear_i) begin
            r_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_o   = (r_q.st == CH_WAIT) && en_i && trig_i && below_cap && !clear_i;
    assign force_o = (r_q.st == CH_ON);
    assign seen_o  = r_q.seen;
    assign occ_o   = r_q.occ;

    // R2: a pulse may only begin out of an enabled trigger window
    a_r2_start_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_o) |-> $past(trig_i && en_i));

    // R4: disabling releases the force line at the next edge
    a_r4_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !force_o);

    // R5: a capped channel never starts another pulse
    a_r5_cap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_o >= occ_limit_i) |=> !$rose(force_o));

    // R8: a forced cycle leaves the sticky flag set
    a_r8_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        (force_o && !clear_i) |=> seen_o);

endmodule

// File: rtl/dist_inject_ctrl.sv
module dist_inject_ctrl #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int OW  = 8,
    parameter int LW  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic [LW-1:0]      seed_i,
    input  logic [NCH-1:0]     enable_i,
    input  logic [NCH-1:0]     trig_i,
    input  logic [NCH*DW-1:0]  on_min_i,
    input  logic [NCH*DW-1:0]  on_max_i,
    input  logic [NCH*DW-1:0]  off_min_i,
    input  logic [NCH*DW-1:0]  off_max_i,
    input  logic [NCH*OW-1:0]  occ_limit_i,
    input  logic [NCH*NCH-1:0] excl_i,
    output logic [NCH-1:0]     force_o,
    output logic [NCH-1:0]     forced_seen_o,
    output logic [NCH*OW-1:0]  occ_count_o
);

    localparam int ROT_STEP = 5;

    logic [LW-1:0]   lfsr_state;
    logic [2*LW-1:0] lfsr_dbl;
    logic [NCH-1:0]  req;
    logic [NCH-1:0]  grant;

    assign lfsr_dbl = {lfsr_state, lfsr_state};

    dist_lfsr #(.LW(LW)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .seed_i  (seed_i),
        .state_o (lfsr_state)
    );

    dist_excl_arb #(.NCH(NCH)) u_arb (
        .req_i   (req),
        .on_i    (force_o),
        .excl_i  (excl_i),
        .grant_o (grant)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int ROT = (c * ROT_STEP) % LW;
        logic [DW-1:0] draw;
        assign draw = lfsr_dbl[ROT +: DW];

        dist_channel #(.DW(DW), .OW(OW)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .clear_i     (clear_i),
            .en_i        (enable_i[c]),
            .trig_i      (trig_i[c]),
            .grant_i     (grant[c]),
            .draw_i      (draw),
            .on_min_i    (on_min_i[c*DW +: DW]),
            .on_max_i    (on_max_i[c*DW +: DW]),
            .off_min_i   (off_min_i[c*DW +: DW]),
            .off_max_i   (off_max_i[c*DW +: DW]),
            .occ_limit_i (occ_limit_i[c*OW +: OW]),
            .req_o       (req[c]),
            .force_o     (force_o[c]),
            .seen_o      (forced_seen_o[c]),
            .occ_o       (occ_count_o[c*OW +: OW])
        );
    end

    logic excl_clash;
    always_comb begin
        excl_clash = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            for (int j = i + 1; j < NCH; j++) begin
                if ((excl_i[i*NCH+j] || excl_i[j*NCH+i]) && force_o[i] && force_o[j]) begin
                    excl_clash = 1'b1;
                end
            end
        end
    end

    // R6: excluded pairs are never forced together
    a_r6_no_excl_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !excl_clash);

    // R1: clear empties every force line on the following edge
    a_r1_clear_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (force_o == '0 && forced_seen_o == '0));

endmodule

// File: tb/dist_inject_ctrl_bench.sv
module dist_inject_ctrl_bench;

    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int OW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear = 1'b0;
    logic [15:0] seed = 16'hACE1;
    logic [NCH-1:0] en = '0;
    logic [NCH-1:0] trig = '0;
    logic [DW-1:0] on_min_a [NCH];
    logic [DW-1:0] on_max_a [NCH];
    logic [DW-1:0] off_min_a [NCH];
    logic [DW-1:0] off_max_a [NCH];
    logic [OW-1:0] lim_a [NCH];
    logic [NCH*NCH-1:0] excl = '0;
    logic [NCH*DW-1:0] on_min_f, on_max_f, off_min_f, off_max_f;
    logic [NCH*OW-1:0] lim_f;
    logic [NCH-1:0] force_w, seen_w;
    logic [NCH*OW-1:0] occ_w;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    for (genvar g = 0; g < NCH; g++) begin : g_pack
        assign on_min_f[g*DW +: DW]  = on_min_a[g];
        assign on_max_f[g*DW +: DW]  = on_max_a[g];
        assign off_min_f[g*DW +: DW] = off_min_a[g];
        assign off_max_f[g*DW +: DW] = off_max_a[g];
        assign lim_f[g*OW +: OW]     = lim_a[g];
    end

    dist_inject_ctrl u_dist_inject_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_i       (clear),
        .seed_i        (seed),
        .enable_i      (en),
        .trig_i        (trig),
        .on_min_i      (on_min_f),
        .on_max_i      (on_max_f),
        .off_min_i     (off_min_f),
        .off_max_i     (off_max_f),
        .occ_limit_i   (lim_f),
        .excl_i        (excl),
        .force_o       (force_w),
        .forced_seen_o (seen_w),
        .occ_count_o   (occ_w)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int occ_of(input int ch);
        return int'(occ_w[ch*OW +: OW]);
    endfunction

    task automatic cfg(input int ch, input int a, input int b, input int c, input int d, input int l);
        on_min_a[ch] = DW'(a); on_max_a[ch] = DW'(b);
        off_min_a[ch] = DW'(c); off_max_a[ch] = DW'(d);
        lim_a[ch] = OW'(l);
    endtask

    task automatic do_clear();
        @(negedge clk);
        en = '0; trig = '0; excl = '0; clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    task automatic wait_rise(input int ch, output int lat);
        lat = 0;
        while (!force_w[ch] && lat < 300) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic count_high(input int ch, output int w);
        w = 0;
        while (force_w[ch] && w < 300) begin
            w++;
            @(negedge clk);
        end
    endtask

    task automatic count_low(input int ch, input int cap, output int g);
        g = 0;
        while (!force_w[ch] && g < cap) begin
            g++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(force_w == '0, "R1 reset force", int'(force_w), 0);
        chk(seen_w == '0, "R1 reset sticky", int'(seen_w), 0);
        chk(occ_w == '0, "R1 reset count", int'(occ_w), 0);
    endtask

    task automatic t_gate_and_fixed();
        int w, g;
        bit any;
        do_clear();
        cfg(0, 3, 3, 2, 2, 2);
        en[0] = 1'b1;
        any = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (force_w[0]) any = 1'b1;
        end
        chk(!any, "R2 no trigger no force", int'(any), 0);
        trig[0] = 1'b1;
        @(negedge clk);
        chk(force_w[0] == 1'b1, "R2 start one edge after trigger", int'(force_w[0]), 1);
        count_high(0, w);
        chk(w == 3, "R3 fixed high length", w, 3);
        count_low(0, 300, g);
        chk(g == 3, "R3 gap equals low phase plus one", g, 3);
        count_high(0, w);
        chk(w == 3, "R3 second high length", w, 3);
        count_low(0, 40, g);
        chk(g == 40, "R5 capped channel stays quiet", g, 40);
        chk(occ_of(0) == 2, "R5 count at limit", occ_of(0), 2);
        chk(seen_w[0] == 1'b1, "R8 sticky after pulses", int'(seen_w[0]), 1);
        do_clear();
        chk(occ_of(0) == 0, "R1 clear zeroes count", occ_of(0), 0);
        chk(seen_w[0] == 1'b0, "R1 clear drops sticky", int'(seen_w[0]), 0);
        chk(force_w == '0, "R1 clear drops force", int'(force_w), 0);
    endtask

    task automatic t_limit_zero();
        int g;
        do_clear();
        cfg(1, 2, 2, 2, 2, 0);
        en[1] = 1'b1; trig[1] = 1'b1;
        count_low(1, 25, g);
        chk(g == 25, "R5 limit 0 never forces", g, 25);
    endtask

    task automatic t_random();
        int w, g;
        do_clear();
        cfg(0, 2, 5, 1, 4, 8);
        en[0] = 1'b1; trig[0] = 1'b1;
        wait_rise(0, g);
        for (int k = 0; k < 5; k++) begin
            count_high(0, w);
            chk(w >= 2 && w <= 5, "R3 random high in window", w, 2);
            count_low(0, 300, g);
            chk(g >= 2 && g <= 5, "R3 random gap in window", g, 2);
        end
    endtask

    task automatic t_disable();
        int lat;
        do_clear();
        cfg(2, 10, 10, 2, 2, 5);
        en[2] = 1'b1; trig[2] = 1'b1;
        wait_rise(2, lat);
        repeat (3) @(negedge clk);
        chk(force_w[2] == 1'b1, "R4 still high before disable", int'(force_w[2]), 1);
        en[2] = 1'b0;
        @(negedge clk);
        chk(force_w[2] == 1'b0, "R4 drop after disable", int'(force_w[2]), 0);
        chk(occ_of(2) == 0, "R4 aborted pulse not counted", occ_of(2), 0);
    endtask

    task automatic t_exclusion();
        int overlap;
        do_clear();
        cfg(0, 4, 4, 3, 3, 3);
        cfg(1, 4, 4, 3, 3, 3);
        excl[1*NCH+0] = 1'b1;
        en[1:0] = 2'b11;
        repeat (2) @(negedge clk);
        trig[1:0] = 2'b11;
        @(negedge clk);
        chk(force_w[0] == 1'b1, "R7 lowest index wins", int'(force_w[0]), 1);
        chk(force_w[1] == 1'b0, "R7 higher index waits", int'(force_w[1]), 0);
        overlap = 0;
        for (int k = 0; k < 60; k++) begin
            if (force_w[0] && force_w[1]) overlap++;
            @(negedge clk);
        end
        chk(overlap == 0, "R6 excluded pair never together", overlap, 0);
        chk(occ_of(1) >= 1, "R6 blocked partner runs later", occ_of(1), 1);
    endtask

    task automatic t_independent();
        do_clear();
        cfg(2, 3, 3, 2, 2, 4);
        cfg(3, 3, 3, 2, 2, 4);
        en[3:2] = 2'b11;
        repeat (2) @(negedge clk);
        trig[3:2] = 2'b11;
        @(negedge clk);
        chk(force_w[3:2] == 2'b11, "R9 unrelated channels together", int'(force_w[3:2]), 3);
        @(negedge clk);
        chk(seen_w[3:2] == 2'b11, "R8 sticky set after force", int'(seen_w[3:2]), 3);
        chk(seen_w[1] == 1'b0, "R8 idle channel not marked", int'(seen_w[1]), 0);
    endtask

    task automatic t_floor();
        int w, lat;
        do_clear();
        cfg(0, 0, 0, 1, 1, 2);
        en[0] = 1'b1; trig[0] = 1'b1;
        wait_rise(0, lat);
        count_high(0, w);
        chk(w == 1, "R3 zero window floors to 1", w, 1);
    endtask

    task automatic run_seq(output int r [6]);
        int lat;
        do_clear();
        cfg(0, 1, 9, 1, 9, 4);
        en[0] = 1'b1; trig[0] = 1'b1;
        wait_rise(0, lat);
        for (int k = 0; k < 3; k++) begin
            count_high(0, r[2*k]);
            count_low(0, 300, r[2*k+1]);
        end
    endtask

    task automatic t_reload();
        int a [6];
        int b [6];
        run_seq(a);
        repeat (7) @(negedge clk);
        run_seq(b);
        for (int k = 0; k < 6; k++) begin
            chk(a[k] == b[k], "R1 seed reload repeats widths", b[k], a[k]);
        end
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) cfg(c, 1, 1, 1, 1, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gate_and_fixed();
        t_limit_zero();
        t_random();
        t_disable();
        t_exclusion();
        t_independent();
        t_floor();
        t_reload();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule